// File: doc/BRIEF.md
# Nine-Bit Symbol Error Patcher

This block repairs a data buffer in place from a short list of error reports produced by a Reed-Solomon decoder. The buffer is a packed stream of 9-bit symbols stored in bytes, so every symbol crosses a byte boundary. For each report the block reads the two bytes that hold the symbol, flips the reported bits with an XOR and writes both bytes back. The buffer lives in a dual-port RAM inside the block. One port belongs to the correction engine. The other port is a plain host port used to fill the buffer before a run and to read the repaired bytes afterwards.

A run starts with a one-cycle `start` pulse. At that cycle the block captures the report count, the report list, the uncorrectable flag and the stored parity bytes. When asked to, the block first checks whether the page is blank: all parity bytes and all buffer bytes equal 0xFF. A blank page is left untouched. The scan reads the first byte, the middle byte and the last byte before the rest, and it stops at the first byte that is not 0xFF. When the run ends, `done` pulses for one cycle. The result outputs then hold their values until the next start.

A separate registered path serves the encode direction. Computed parity that equals the parity of a blank page is replaced by nine 0xFF bytes, so blank pages stay uniformly blank.

Top module: `sym9_patcher`

## Requirements
- R1: A report index is one-based. Raw value 0, and any raw value above NSYM, is ignored: the buffer is unchanged and the report is not counted.
- R2: For a valid raw index r, let k = r-1. The low byte address is k + (k>>3) and the bit offset is k mod 8. Mask bit 0 lands on bit `offset` of the 16-bit word formed by the high byte at address+1 and the low byte at address.
- R3: Only the 9 addressed bits are XORed with the mask. Every other bit of the two bytes, and every other byte of the buffer, keeps its value.
- R4: Entries 0 to `rpt_cnt`-1 of the report list are applied in order. A count of 0 applies none. `fix_cnt` equals the number of reports actually applied.
- R5: If `uncorr` is high at start, no byte is modified, `fail` is 1 and `fix_cnt` is 0.
- R6: With `chk_erased` high, if all 9 parity bytes and all buffer bytes are 0xFF, no report is applied, `erased` is 1 and `fix_cnt` is 0.
- R7: In each of these cases the reports are applied normally and `erased` is 0: `chk_erased` is low, any parity byte is not 0xFF, or any buffer byte is not 0xFF.
- R8: `done` is high for exactly one cycle per run. `fail`, `erased` and `fix_cnt` are valid with `done` and hold their values until the next start.
- R9: One cycle after `enc_par_in`, `enc_par_out` shows all ones when the input bytes are CD 9D 90 58 F4 8B FF B7 6F (byte 0 in bits 7:0). Any other input passes through unchanged.
- R10: After reset, `done`, `fail` and `erased` are 0 and `fix_cnt` is 0.
- R11: A host write with `host_we` stores `host_wdata` at `host_addr`. `host_rdata` returns the byte at `host_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a run |
| chk_erased | input | 1 | Enables the blank-page check |
| uncorr | input | 1 | Decoder reported an uncorrectable block |
| rpt_cnt | input | CNT_W | Number of reports to apply |
| rpt_idx | input | MAX_RPT*RIDX_W | One-based symbol indices; entry j at bits [j*RIDX_W +: RIDX_W] |
| rpt_mask | input | MAX_RPT*9 | 9-bit error masks; entry j at bits [j*9 +: 9] |
| par_in | input | 72 | Stored parity bytes; byte i at bits [8i +: 8] |
| done | output | 1 | Run complete pulse |
| fail | output | 1 | Run rejected as uncorrectable |
| erased | output | 1 | Page was found blank and was skipped |
| fix_cnt | output | CNT_W | Reports applied in the last run |
| host_we | input | 1 | Host byte write enable |
| host_addr | input | AW | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one-cycle latency |
| enc_par_in | input | 72 | Computed parity in the encode direction |
| enc_par_out | output | 72 | Encode parity after blank substitution |

## Verification
A wrong byte address or bit offset inside the engine shows up as corrupted neighbour bytes in the host readback of the same run. The bench sweeps every raw index, including 0 and the values past the end, so an error in the index arithmetic shows for the indices it affects. A stuck or misordered state shows at the ports one run later. It appears either as a missing or lengthened `done` pulse or as a `fix_cnt` that differs from the count of valid reports. A blank-page check that misreads a byte shows in the same run: the patch is either skipped or wrongly applied, and `erased` disagrees with the fill pattern.

// File: rtl/sym9_pkg.sv
package sym9_pkg;
  localparam int SYM_W     = 9;
  localparam int PAR_BYTES = 9;
  localparam int PAR_W     = PAR_BYTES * 8;

  // parity of an all-ones page, byte 0 in the low bits
  localparam logic [PAR_W-1:0] BLANK_PAR =
    {8'h6F, 8'hB7, 8'hFF, 8'h8B, 8'hF4, 8'h58, 8'h90, 8'h9D, 8'hCD};

  typedef enum logic [2:0] {
    ST_IDLE, ST_SCAN, ST_SEL, ST_RD0, ST_RD1, ST_WR0, ST_WR1
  } eng_st_t;
endpackage

// File: rtl/sym_buf_ram.sv
module sym_buf_ram #(
  parameter int DEPTH = 576,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [7:0]    a_wdata,
  output logic [7:0]    a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [7:0]    b_wdata,
  output logic [7:0]    b_rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/sym_locator.sv
module sym_locator #(
  parameter int NSYM      = 512,
  parameter int RIDX_W    = 10,
  parameter int AW        = 10,
  parameter int BUF_BYTES = 576
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RIDX_W-1:0] raw_idx,
  output logic              valid,
  output logic [AW-1:0]     byte_addr,
  output logic [2:0]        bit_off
);
  logic [RIDX_W-1:0] k;

  always_comb begin
    k         = raw_idx - 1'b1;
    valid     = (raw_idx != '0) && (int'(raw_idx) <= NSYM);
    byte_addr = AW'(k) + AW'(k >> 3);
    bit_off   = k[2:0];
  end

  // R2: a valid symbol must fit with its upper byte inside the buffer
  always_ff @(posedge clk) begin
    if (!rst) begin
      a_r2_addr_range: assert (!valid || (int'(byte_addr) + 1 < BUF_BYTES))
        else $error("symbol address outside buffer");
    end
  end
endmodule

// File: rtl/blank_par_fix.sv
module blank_par_fix
  import sym9_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [PAR_W-1:0] par_in,
  output logic [PAR_W-1:0] par_out
);
  always_ff @(posedge clk) begin
    if (rst) par_out <= '0;
    else     par_out <= (par_in == BLANK_PAR) ? {PAR_W{1'b1}} : par_in;
  end

  a_r9_blank_to_ones: assert property (@(posedge clk) disable iff (rst)
    (par_in == BLANK_PAR) |=> (par_out == {PAR_W{1'b1}}));
  a_r9_pass_through: assert property (@(posedge clk) disable iff (rst)
    (par_in != BLANK_PAR) |=> (par_out == $past(par_in)));
endmodule

// File: rtl/sym9_patcher.sv
module sym9_patcher
  import sym9_pkg::*;
#(
  parameter int NSYM  = 512,
  parameter int CNT_W = 3,
  localparam int BUF_BYTES = NSYM + NSYM / 8,
  localparam int AW        = $clog2(BUF_BYTES),
  localparam int RIDX_W    = $clog2(NSYM) + 1,
  localparam int MAX_RPT   = (1 << CNT_W) - 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      chk_erased,
  input  logic                      uncorr,
  input  logic [CNT_W-1:0]          rpt_cnt,
  input  logic [MAX_RPT*RIDX_W-1:0] rpt_idx,
  input  logic [MAX_RPT*SYM_W-1:0]  rpt_mask,
  input  logic [PAR_W-1:0]          par_in,
  output logic                      done,
  output logic                      fail,
  output logic                      erased,
  output logic [CNT_W-1:0]          fix_cnt,
  input  logic                      host_we,
  input  logic [AW-1:0]             host_addr,
  input  logic [7:0]                host_wdata,
  output logic [7:0]                host_rdata,
  input  logic [PAR_W-1:0]          enc_par_in,
  output logic [PAR_W-1:0]          enc_par_out
);
  localparam int NSLOT = 1 << CNT_W;
  localparam int STEPS = BUF_BYTES + 1;
  localparam int SW    = AW + 1;

  eng_st_t state;

  logic [RIDX_W-1:0] idx_q [NSLOT];
  logic [SYM_W-1:0]  msk_q [NSLOT];
  logic [CNT_W-1:0]  cnt_q, slot;

  logic [AW-1:0]     addr_q;
  logic [2:0]        off_q;
  logic [SYM_W-1:0]  cur_msk;
  logic [7:0]        lo_q, hi_q;
  logic [SW-1:0]     step;
  logic              chk_vld;

  logic              loc_valid;
  logic [AW-1:0]     loc_addr;
  logic [2:0]        loc_off;

  logic              eng_we;
  logic [AW-1:0]     eng_addr;
  logic [7:0]        eng_wdata, eng_rdata;
  logic [AW-1:0]     scan_addr;
  logic [15:0]       patched;

  sym_buf_ram #(.DEPTH(BUF_BYTES), .AW(AW)) u_buf (
    .clk(clk),
    .a_we(eng_we), .a_addr(eng_addr), .a_wdata(eng_wdata), .a_rdata(eng_rdata),
    .b_we(host_we), .b_addr(host_addr), .b_wdata(host_wdata), .b_rdata(host_rdata)
  );

  sym_locator #(.NSYM(NSYM), .RIDX_W(RIDX_W), .AW(AW), .BUF_BYTES(BUF_BYTES)) u_loc (
    .clk(clk), .rst(rst), .raw_idx(idx_q[slot]),
    .valid(loc_valid), .byte_addr(loc_addr), .bit_off(loc_off)
  );

  blank_par_fix u_enc (
    .clk(clk), .rst(rst), .par_in(enc_par_in), .par_out(enc_par_out)
  );

  // scan order: first, middle, last, then the remaining bytes upward
  always_comb begin
    if (step == SW'(0))      scan_addr = '0;
    else if (step == SW'(1)) scan_addr = AW'(BUF_BYTES / 2);
    else if (step == SW'(2)) scan_addr = AW'(BUF_BYTES - 1);
    else                     scan_addr = AW'(step - SW'(2));
  end

  assign patched = {eng_rdata, lo_q} ^ (16'(cur_msk) << off_q);

  always_comb begin
    eng_we    = 1'b0;
    eng_addr  = addr_q;
    eng_wdata = hi_q;
    unique case (state)
      ST_SCAN: eng_addr = scan_addr;
      ST_RD1:  eng_addr = addr_q + 1'b1;
      ST_WR0: begin
        eng_we    = 1'b1;
        eng_wdata = patched[7:0];
      end
      ST_WR1: begin
        eng_we   = 1'b1;
        eng_addr = addr_q + 1'b1;
      end
      default: eng_addr = addr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      fail    <= 1'b0;
      erased  <= 1'b0;
      fix_cnt <= '0;
      cnt_q   <= '0;
      slot    <= '0;
      addr_q  <= '0;
      off_q   <= '0;
      cur_msk <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      step    <= '0;
      chk_vld <= 1'b0;
      for (int j = 0; j < NSLOT; j++) begin
        idx_q[j] <= '0;
        msk_q[j] <= '0;
      end
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          cnt_q   <= rpt_cnt;
          slot    <= '0;
          fix_cnt <= '0;
          fail    <= 1'b0;
          erased  <= 1'b0;
          step    <= '0;
          chk_vld <= 1'b0;
          for (int j = 0; j < NSLOT; j++) begin
            idx_q[j] <= (j < MAX_RPT) ? rpt_idx[j*RIDX_W +: RIDX_W] : '0;
            msk_q[j] <= (j < MAX_RPT) ? rpt_mask[j*SYM_W +: SYM_W] : '0;
          end
          if (uncorr) begin
            fail <= 1'b1;
            done <= 1'b1;
          end else if (chk_erased && (&par_in)) begin
            state <= ST_SCAN;
          end else begin
            state <= ST_SEL;
          end
        end
        ST_SCAN: begin
          if (chk_vld && eng_rdata != 8'hFF) begin
            state <= ST_SEL;
          end else if (chk_vld && step == SW'(STEPS)) begin
            erased <= 1'b1;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            step    <= step + 1'b1;
            chk_vld <= 1'b1;
          end
        end
        ST_SEL: begin
          if (slot == cnt_q) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            slot <= slot + 1'b1;
            if (loc_valid) begin
              addr_q  <= loc_addr;
              off_q   <= loc_off;
              cur_msk <= msk_q[slot];
              state   <= ST_RD0;
            end
          end
        end
        ST_RD0: state <= ST_RD1;
        ST_RD1: begin
          lo_q  <= eng_rdata;
          state <= ST_WR0;
        end
        ST_WR0: begin
          hi_q  <= patched[15:8];
          state <= ST_WR1;
        end
        ST_WR1: begin
          fix_cnt <= fix_cnt + 1'b1;
          state   <= ST_SEL;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R4: never more corrections than reports requested
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    done |-> (fix_cnt <= cnt_q));
  // R5: a rejected run applies nothing
  a_r5_fail_nofix: assert property (@(posedge clk) disable iff (rst)
    (done && fail) |-> (fix_cnt == '0 && !erased));
  // R6: a blank page applies nothing
  a_r6_erased_nofix: assert property (@(posedge clk) disable iff (rst)
    (done && erased) |-> (fix_cnt == '0 && !fail));
  // R2: the low-byte write is followed by the high-byte write at the next address
  a_r2_write_pair: assert property (@(posedge clk) disable iff (rst)
    (eng_we && !$past(eng_we)) |=> (eng_we && eng_addr == $past(eng_addr) + 1'b1));
endmodule

// File: tb/test_sym9_patcher.sv
`timescale 1ns/1ps
module test_sym9_patcher;
  localparam int NSYM   = 32;
  localparam int CNT_W  = 3;
  localparam int BUF    = NSYM + NSYM / 8;
  localparam int AW     = $clog2(BUF);
  localparam int RIDX_W = $clog2(NSYM) + 1;
  localparam int MAXR   = (1 << CNT_W) - 1;
  localparam logic [71:0] BLANK =
    {8'h6F, 8'hB7, 8'hFF, 8'h8B, 8'hF4, 8'h58, 8'h90, 8'h9D, 8'hCD};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                    rst, start, chk_erased, uncorr;
  logic [CNT_W-1:0]        rpt_cnt;
  logic [MAXR*RIDX_W-1:0]  rpt_idx;
  logic [MAXR*9-1:0]       rpt_mask;
  logic [71:0]             par_in, enc_par_in, enc_par_out;
  logic                    done, fail, erased;
  logic [CNT_W-1:0]        fix_cnt;
  logic                    host_we;
  logic [AW-1:0]           host_addr;
  logic [7:0]              host_wdata, host_rdata;

  logic [RIDX_W-1:0] t_idx [MAXR];
  logic [8:0]        t_msk [MAXR];
  logic [7:0]        model [BUF];
  int errors = 0, checks = 0, applied = 0;
  logic r_fail, r_erased;
  logic [CNT_W-1:0] r_cnt;

  always_comb begin
    for (int j = 0; j < MAXR; j++) begin
      rpt_idx[j*RIDX_W +: RIDX_W] = t_idx[j];
      rpt_mask[j*9 +: 9]          = t_msk[j];
    end
  end

  sym9_patcher #(.NSYM(NSYM), .CNT_W(CNT_W)) i_sym9_patcher (
    .clk(clk), .rst(rst), .start(start), .chk_erased(chk_erased), .uncorr(uncorr),
    .rpt_cnt(rpt_cnt), .rpt_idx(rpt_idx), .rpt_mask(rpt_mask), .par_in(par_in),
    .done(done), .fail(fail), .erased(erased), .fix_cnt(fix_cnt),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .enc_par_in(enc_par_in), .enc_par_out(enc_par_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fill_model(input int seed);
    for (int i = 0; i < BUF; i++) model[i] = 8'(i * 29 + seed * 7 + 3);
  endtask

  task automatic model_apply(input int raw, input logic [8:0] m);
    int k, a, off;
    logic [15:0] w;
    if (raw >= 1 && raw <= NSYM) begin
      k = raw - 1; a = k + k / 8; off = k % 8;
      w = {model[a+1], model[a]} ^ (16'(m) << off);
      model[a] = w[7:0]; model[a+1] = w[15:8];
      applied++;
    end
  endtask

  task automatic load_dut;
    for (int i = 0; i < BUF; i++) begin
      @(negedge clk);
      host_we = 1'b1; host_addr = AW'(i); host_wdata = model[i];
    end
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic verify_buf(input string req);
    int bad = 0;
    logic [7:0] act = 0, exp = 0;
    for (int i = 0; i < BUF; i++) begin
      @(negedge clk); host_addr = AW'(i);
      @(negedge clk);
      if (host_rdata !== model[i] && bad == 0) begin
        act = host_rdata; exp = model[i];
      end
      if (host_rdata !== model[i]) bad++;
    end
    chk(bad == 0, req, "buffer byte", act, exp);
  endtask

  task automatic run_op(input logic [CNT_W-1:0] cnt, input logic unc,
                        input logic ce, input logic [71:0] par);
    int n = 0;
    @(negedge clk);
    rpt_cnt = cnt; uncorr = unc; chk_erased = ce; par_in = par; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 5000) begin
      @(negedge clk); n++;
    end
    chk(done === 1'b1, "R8", "done seen", done, 1);
    r_fail = fail; r_erased = erased; r_cnt = fix_cnt;
    @(negedge clk);
    chk(done === 1'b0, "R8", "done one cycle", done, 0);
    chk(fix_cnt === r_cnt && fail === r_fail, "R8", "results held", fix_cnt, r_cnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 0; chk_erased = 0; uncorr = 0; rpt_cnt = 0;
    par_in = '0; enc_par_in = '0; host_we = 0; host_addr = '0; host_wdata = '0;
    for (int j = 0; j < MAXR; j++) begin t_idx[j] = '0; t_msk[j] = '0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10
    chk(done === 0 && fail === 0 && erased === 0, "R10", "flags after reset",
        {done, fail, erased}, 0);
    chk(fix_cnt === 0, "R10", "count after reset", fix_cnt, 0);

    // R11: host write then read
    @(negedge clk); host_we = 1; host_addr = AW'(7); host_wdata = 8'hA5;
    @(negedge clk); host_we = 0;
    @(negedge clk);
    chk(host_rdata === 8'hA5, "R11", "host readback", host_rdata, 8'hA5);

    // R1 R2 R3 R4: sweep every raw index with one report
    for (int raw = 0; raw <= NSYM + 2; raw++) begin
      logic [8:0] m;
      m = 9'((raw * 53 + 7)) | 9'h001;
      if (raw % 5 == 0) m = 9'h1FF;
      fill_model(raw);
      load_dut();
      t_idx[0] = RIDX_W'(raw); t_msk[0] = m;
      applied = 0;
      model_apply(raw, m);
      run_op(3'd1, 0, 0, '0);
      chk(r_cnt == CNT_W'(applied), (raw == 0 || raw > NSYM) ? "R1" : "R4",
          "single report count", r_cnt, applied);
      verify_buf((raw == 0 || raw > NSYM) ? "R1" : "R2_R3");
    end

    // R4: seven reports incl. repeat and invalid entries
    t_idx[0] = 3;  t_msk[0] = 9'h101; t_idx[1] = 0;  t_msk[1] = 9'h1FF;
    t_idx[2] = 9;  t_msk[2] = 9'h0F0; t_idx[3] = 3;  t_msk[3] = 9'h011;
    t_idx[4] = 32; t_msk[4] = 9'h1AA; t_idx[5] = 40; t_msk[5] = 9'h1FF;
    t_idx[6] = 17; t_msk[6] = 9'h155;
    fill_model(50); load_dut(); applied = 0;
    for (int j = 0; j < 7; j++) model_apply(int'(t_idx[j]), t_msk[j]);
    run_op(3'd7, 0, 0, '0);
    chk(r_cnt == CNT_W'(applied), "R4", "seven reports count", r_cnt, applied);
    verify_buf("R4");

    // R4: only the first four entries
    fill_model(51); load_dut(); applied = 0;
    for (int j = 0; j < 4; j++) model_apply(int'(t_idx[j]), t_msk[j]);
    run_op(3'd4, 0, 0, '0);
    chk(r_cnt == CNT_W'(applied), "R4", "partial count", r_cnt, applied);
    verify_buf("R4");

    // R4: zero reports
    fill_model(52); load_dut();
    run_op(3'd0, 0, 0, '0);
    chk(r_cnt == 0, "R4", "zero reports", r_cnt, 0);
    verify_buf("R4");

    // R5: uncorrectable
    fill_model(53); load_dut();
    run_op(3'd7, 1, 0, '0);
    chk(r_fail === 1 && r_cnt == 0, "R5", "fail flag and count", {r_fail, r_cnt}, 8);
    verify_buf("R5");

    // R6: blank page skipped
    for (int i = 0; i < BUF; i++) model[i] = 8'hFF;
    load_dut();
    run_op(3'd3, 0, 1, {72{1'b1}});
    chk(r_erased === 1 && r_cnt == 0 && r_fail === 0, "R6", "blank skip",
        {r_erased, r_cnt}, 8);
    verify_buf("R6");

    // R7: one non-blank byte at several positions
    for (int p = 0; p < 5; p++) begin
      int pos;
      pos = (p == 0) ? 0 : (p == 1) ? BUF / 2 : (p == 2) ? BUF - 1 : (p == 3) ? 5 : 20;
      for (int i = 0; i < BUF; i++) model[i] = 8'hFF;
      model[pos] = 8'h7F;
      load_dut(); applied = 0;
      for (int j = 0; j < 3; j++) model_apply(int'(t_idx[j]), t_msk[j]);
      run_op(3'd3, 0, 1, {72{1'b1}});
      chk(r_erased === 0 && r_cnt == CNT_W'(applied), "R7", "non-blank byte",
          {r_erased, r_cnt}, applied);
      verify_buf("R7");
    end

    // R7: parity not blank, data blank
    for (int i = 0; i < BUF; i++) model[i] = 8'hFF;
    load_dut(); applied = 0;
    for (int j = 0; j < 3; j++) model_apply(int'(t_idx[j]), t_msk[j]);
    run_op(3'd3, 0, 1, {{64{1'b1}}, 8'hFE});
    chk(r_erased === 0 && r_cnt == CNT_W'(applied), "R7", "parity not blank",
        {r_erased, r_cnt}, applied);
    verify_buf("R7");

    // R7: check disabled
    for (int i = 0; i < BUF; i++) model[i] = 8'hFF;
    load_dut(); applied = 0;
    for (int j = 0; j < 3; j++) model_apply(int'(t_idx[j]), t_msk[j]);
    run_op(3'd3, 0, 0, {72{1'b1}});
    chk(r_erased === 0 && r_cnt == CNT_W'(applied), "R7", "check disabled",
        {r_erased, r_cnt}, applied);
    verify_buf("R7");

    // R9: encode substitution
    @(negedge clk); enc_par_in = BLANK;
    @(negedge clk);
    chk(enc_par_out === {72{1'b1}}, "R9", "blank parity replaced", enc_par_out, {72{1'b1}});
    enc_par_in = BLANK ^ 72'h1;
    @(negedge clk);
    chk(enc_par_out === (BLANK ^ 72'h1), "R9", "other parity kept", enc_par_out, BLANK ^ 72'h1);
    enc_par_in = 72'h0123_4567_89AB_CDEF_55;
    @(negedge clk);
    chk(enc_par_out === 72'h0123_4567_89AB_CDEF_55, "R9", "arbitrary parity kept",
        enc_par_out, 72'h0123_4567_89AB_CDEF_55);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule